// File: doc/BRIEF.md
# Task Context Restore Sequencer

This block reloads a task's working registers from its stack in several cycles. On a start pulse it captures three operands: a 16-bit RAM address that holds the current task number, a 20-bit base address of a per-task descriptor table, and the current stack pointer. It reads the task number and uses it to index the table, where two bytes per task give a register-selection mask and a stack-correction byte. It then reads the selected registers from the stack as byte pairs and drives each finished 16-bit word onto a register-file write port. Last, it writes the corrected stack pointer back.

Every memory access goes through one byte-wide read port. The port holds its request and address until the memory returns valid data, so the block works with any memory latency. Because the mask and the correction byte come from a table indexed by task number, the number and order of stack reads differ from one task to the next.

Top module: `ctx_restore_seq`

## Requirements
- R1: The first read after an accepted start is at address {4'h0, task_ptr_i}. The byte it returns is the task number n (0 to 255).
- R2: The second read is at E = (tbl_base_i + 2n) mod 2^20 and returns the selection mask. The third read is at (E + 1) mod 2^20 and returns the correction byte.
- R3: Mask bit b selects register code b on reg_idx_o (0=R0, 1=R1, 2=R2, 3=R3, 4=A0, 5=A1, 6=SB, 7=FB). Only registers whose bit is 1 are written, with exactly one reg_we_o pulse each. A register whose bit is 0 is never written.
- R4: Selected registers are restored in ascending code order. Each one takes two stack reads: the low byte first, then the high byte. The reads start at the captured SP and step up by one byte address each time, with address k equal to {4'h0, (SP + k) mod 2^16}. reg_wdata_o is {high, low}.
- R5: When the operation ends, sp_wdata_o equals (SP + zero-extended correction byte) mod 2^16.
- R6: An all-zero mask causes no stack reads and no register writes. The SP correction is still applied.
- R7: done_o is high for exactly one cycle per operation. sp_we_o is high in that same cycle and in no other, and no read is requested in that cycle.
- R8: While mem_req_o is high and mem_rvalid_i is low, mem_req_o and mem_addr_o stay unchanged. A read completes in the cycle where both are high, whatever the latency.
- R9: A start pulse while an operation is in progress is ignored. The running sequence keeps its captured operands.
- R10: During and after reset, done_o, mem_req_o, reg_we_o and sp_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| task_ptr_i | input | 16 | RAM address holding the task number |
| tbl_base_i | input | 20 | Base address of the descriptor table |
| sp_i | input | 16 | Current stack pointer, captured at start |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 20 | Read byte address |
| mem_rdata_i | input | 8 | Read data |
| mem_rvalid_i | input | 1 | Read data valid |
| reg_we_o | output | 1 | Register write strobe |
| reg_idx_o | output | 3 | Register code being written |
| reg_wdata_o | output | 16 | Restored register value |
| sp_we_o | output | 1 | Stack pointer write strobe |
| sp_wdata_o | output | 16 | Corrected stack pointer |

## Verification
The bench targets table addresses that wrap past the top of the 20-bit space and stack reads that wrap past 16'hFFFF. A design that carried or failed to wrap there would fetch the wrong mask or the wrong stack bytes. It also runs an empty mask, a full mask and sparse masks: a sequencer that scanned in the wrong direction, paired the bytes the wrong way round or skipped the empty-mask shortcut would show a wrong write order, wrong data or extra reads. Memory latencies from zero to three cycles catch a design that moves its address before valid data arrives. A start pulse in mid-operation and a reset in mid-operation must leave the running result, and the idle outputs afterwards, unchanged.

// File: rtl/ctx_pkg.sv
// Shared types for the context restore sequencer.
// Assumes: one operation in flight at a time.
package ctx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_TASK = 3'd1,
        ST_MASK = 3'd2,
        ST_CORR = 3'd3,
        ST_LO   = 3'd4,
        ST_HI   = 3'd5,
        ST_FIN  = 3'd6
    } ctx_state_e;
endpackage

// File: rtl/ctx_lsb_pick.sv
// Lowest-set-bit finder: reports the index of the lowest 1 in vec_i
// and whether any bit is set. Purely combinational.
// Assumes: IDXW is wide enough to encode N-1.
module ctx_lsb_pick #(
    parameter int N    = 8,
    parameter int IDXW = 3
) (
    input  logic [N-1:0]    vec_i,
    output logic [IDXW-1:0] idx_o,
    output logic            any_o
);
    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IDXW'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ctx_seq_ctrl.sv
// Control FSM: steps through the task read, the mask read, the correction
// read and the low/high byte pops, then a finish cycle. It holds the set
// of registers still to be restored and the correction byte.
// Assumes: a read completes in a cycle where mem_req_o and rd_valid_i are both high.
module ctx_seq_ctrl
    import ctx_pkg::*;
#(
    parameter int NREG = 8,
    parameter int IDXW = 3,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            rd_valid_i,
    input  logic [DW-1:0]   rd_data_i,
    input  logic [IDXW-1:0] pick_idx_i,
    input  logic            pick_any_i,
    output ctx_state_e      state_o,
    output logic            load_o,
    output logic            mem_req_o,
    output logic            rd_done_o,
    output logic [NREG-1:0] pend_o,
    output logic [DW-1:0]   corr_o
);
    ctx_state_e      state_q, state_d;
    logic [NREG-1:0] pend_q;
    logic [NREG-1:0] pend_left;
    logic [DW-1:0]   corr_q;

    assign state_o   = state_q;
    assign pend_o    = pend_q;
    assign corr_o    = corr_q;
    assign load_o    = (state_q == ST_IDLE) && start_i;
    assign mem_req_o = (state_q == ST_TASK) || (state_q == ST_MASK) ||
                       (state_q == ST_CORR) || (state_q == ST_LO)   ||
                       (state_q == ST_HI);
    assign rd_done_o = mem_req_o && rd_valid_i;
    assign pend_left = pend_q & ~(NREG'(1) << pick_idx_i);

    // Next-state selection for the restore sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)   state_d = ST_TASK;
            ST_TASK: if (rd_done_o) state_d = ST_MASK;
            ST_MASK: if (rd_done_o) state_d = ST_CORR;
            ST_CORR: if (rd_done_o) state_d = pick_any_i ? ST_LO : ST_FIN;
            ST_LO:   if (rd_done_o) state_d = ST_HI;
            ST_HI:   if (rd_done_o) state_d = (|pend_left) ? ST_LO : ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pending-register mask: loaded from the table, one bit retired per popped word.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 pend_q <= '0;
        else if (state_q == ST_MASK && rd_done_o)   pend_q <= NREG'(rd_data_i);
        else if (state_q == ST_HI && rd_done_o)     pend_q <= pend_left;
    end

    // Correction byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n)                               corr_q <= '0;
        else if (state_q == ST_CORR && rd_done_o) corr_q <= rd_data_i;
    end

    // R3
    popped_bit_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HI && rd_done_o) |-> pend_q[pick_idx_i]);
    // R7
    fin_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIN) |=> (state_q == ST_IDLE));
    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LO && start_i && !rd_valid_i) |=> (state_q == ST_LO));
endmodule

// File: rtl/ctx_addr_unit.sv
// Address unit: latches the operands at start, forms the table entry
// address from the task number, counts stack bytes, drives the read
// address and forms the corrected stack pointer.
// Assumes: AW > SPW and AW >= DW + 1; table arithmetic wraps modulo 2^AW,
// stack arithmetic modulo 2^SPW.
module ctx_addr_unit
    import ctx_pkg::*;
#(
    parameter int AW  = 20,
    parameter int PW  = 16,
    parameter int SPW = 16,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  ctx_state_e     state_i,
    input  logic           rd_done_i,
    input  logic [DW-1:0]  rd_data_i,
    input  logic [PW-1:0]  task_ptr_i,
    input  logic [AW-1:0]  tbl_base_i,
    input  logic [SPW-1:0] sp_i,
    input  logic [DW-1:0]  corr_i,
    output logic [AW-1:0]  mem_addr_o,
    output logic [SPW-1:0] sp_next_o
);
    logic [PW-1:0]  ptr_q;
    logic [AW-1:0]  base_q;
    logic [AW-1:0]  entry_q;
    logic [SPW-1:0] sp_q;
    logic [SPW-1:0] off_q;
    logic [SPW-1:0] stk_ptr;
    logic [AW-1:0]  tbl_off;

    assign stk_ptr   = sp_q + off_q;
    assign tbl_off   = {{(AW-DW-1){1'b0}}, rd_data_i, 1'b0};
    assign sp_next_o = sp_q + {{(SPW-DW){1'b0}}, corr_i};

    // Operand capture at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            base_q <= '0;
            sp_q   <= '0;
        end else if (load_i) begin
            ptr_q  <= task_ptr_i;
            base_q <= tbl_base_i;
            sp_q   <= sp_i;
        end
    end

    // Table entry address, formed once the task number arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)                                entry_q <= '0;
        else if (state_i == ST_TASK && rd_done_i)  entry_q <= base_q + tbl_off;
    end

    // Stack byte offset: cleared at start, advanced on each popped byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       off_q <= '0;
        else if (load_i)  off_q <= '0;
        else if ((state_i == ST_LO || state_i == ST_HI) && rd_done_i)
                          off_q <= off_q + SPW'(1);
    end

    // Read address selection by phase.
    always_comb begin
        unique case (state_i)
            ST_TASK:      mem_addr_o = {{(AW-PW){1'b0}}, ptr_q};
            ST_MASK:      mem_addr_o = entry_q;
            ST_CORR:      mem_addr_o = entry_q + AW'(1);
            ST_LO, ST_HI: mem_addr_o = {{(AW-SPW){1'b0}}, stk_ptr};
            default:      mem_addr_o = '0;
        endcase
    end

    // R4
    stack_offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_LO && rd_done_i) |=> (off_q == $past(off_q) + SPW'(1)));
endmodule

// File: rtl/ctx_word_pack.sv
// Word packer: holds the low stack byte and, when the high byte arrives,
// issues one registered write of {high, low} to the register file.
// Assumes: a low byte always comes before its high byte.
module ctx_word_pack #(
    parameter int DW   = 8,
    parameter int RW   = 16,
    parameter int IDXW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lo_cap_i,
    input  logic            hi_cap_i,
    input  logic [DW-1:0]   rd_data_i,
    input  logic [IDXW-1:0] idx_i,
    output logic            reg_we_o,
    output logic [IDXW-1:0] reg_idx_o,
    output logic [RW-1:0]   reg_wdata_o
);
    logic [DW-1:0] lo_q;

    // Low byte holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)        lo_q <= '0;
        else if (lo_cap_i) lo_q <= rd_data_i;
    end

    // Register write port, pulsed for one cycle per restored word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_we_o    <= 1'b0;
            reg_idx_o   <= '0;
            reg_wdata_o <= '0;
        end else begin
            reg_we_o <= hi_cap_i;
            if (hi_cap_i) begin
                reg_idx_o   <= idx_i;
                reg_wdata_o <= RW'({rd_data_i, lo_q});
            end
        end
    end

    // R3
    write_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);
endmodule

// File: rtl/ctx_restore_seq.sv
// Top of the task context restore sequencer. It wires the control FSM,
// the address unit, the lowest-bit picker and the word packer.
// Assumes: the stack pointer is stable only at start (it is captured then);
// memory holds data stable while returning it with mem_rvalid_i.
module ctx_restore_seq
    import ctx_pkg::*;
#(
    parameter int AW   = 20,
    parameter int PW   = 16,
    parameter int SPW  = 16,
    parameter int DW   = 8,
    parameter int NREG = 8,
    localparam int RW   = 2 * DW,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [PW-1:0]   task_ptr_i,
    input  logic [AW-1:0]   tbl_base_i,
    input  logic [SPW-1:0]  sp_i,
    output logic            done_o,
    output logic            mem_req_o,
    output logic [AW-1:0]   mem_addr_o,
    input  logic [DW-1:0]   mem_rdata_i,
    input  logic            mem_rvalid_i,
    output logic            reg_we_o,
    output logic [IDXW-1:0] reg_idx_o,
    output logic [RW-1:0]   reg_wdata_o,
    output logic            sp_we_o,
    output logic [SPW-1:0]  sp_wdata_o
);
    ctx_state_e      state;
    logic            load;
    logic            rd_done;
    logic [NREG-1:0] pend;
    logic [DW-1:0]   corr;
    logic [IDXW-1:0] pick_idx;
    logic            pick_any;

    ctx_seq_ctrl #(.NREG(NREG), .IDXW(IDXW), .DW(DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .rd_valid_i (mem_rvalid_i),
        .rd_data_i  (mem_rdata_i),
        .pick_idx_i (pick_idx),
        .pick_any_i (pick_any),
        .state_o    (state),
        .load_o     (load),
        .mem_req_o  (mem_req_o),
        .rd_done_o  (rd_done),
        .pend_o     (pend),
        .corr_o     (corr)
    );

    ctx_lsb_pick #(.N(NREG), .IDXW(IDXW)) u_pick (
        .vec_i (pend),
        .idx_o (pick_idx),
        .any_o (pick_any)
    );

    ctx_addr_unit #(.AW(AW), .PW(PW), .SPW(SPW), .DW(DW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .state_i    (state),
        .rd_done_i  (rd_done),
        .rd_data_i  (mem_rdata_i),
        .task_ptr_i (task_ptr_i),
        .tbl_base_i (tbl_base_i),
        .sp_i       (sp_i),
        .corr_i     (corr),
        .mem_addr_o (mem_addr_o),
        .sp_next_o  (sp_wdata_o)
    );

    ctx_word_pack #(.DW(DW), .RW(RW), .IDXW(IDXW)) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .lo_cap_i    ((state == ST_LO) && rd_done),
        .hi_cap_i    ((state == ST_HI) && rd_done),
        .rd_data_i   (mem_rdata_i),
        .idx_i       (pick_idx),
        .reg_we_o    (reg_we_o),
        .reg_idx_o   (reg_idx_o),
        .reg_wdata_o (reg_wdata_o)
    );

    assign done_o  = (state == ST_FIN);
    assign sp_we_o = (state == ST_FIN);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7
    done_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o);
endmodule

// File: tb/ctx_restore_seq_tb.sv
module ctx_restore_seq_tb;
    typedef struct packed {
        logic [15:0] ptr;
        logic [19:0] base;
        logic [7:0]  tsk;
        logic [7:0]  mask;
        logic [7:0]  corr;
        logic [15:0] sp;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'h0100, 20'h20000, 8'd5,   8'hA5, 8'd8,   16'h8000, 4'd0},
        '{16'h0200, 20'h30000, 8'd255, 8'hFF, 8'd16,  16'h9000, 4'd2},
        '{16'h0300, 20'hFFFFF, 8'd0,   8'h81, 8'd4,   16'h7000, 4'd1},
        '{16'h0400, 20'hFFFFF, 8'd128, 8'h00, 8'hFF,  16'hFF80, 4'd0},
        '{16'h5555, 20'h12345, 8'd7,   8'h0F, 8'd8,   16'hFFFE, 4'd3},
        '{16'h0600, 20'h40000, 8'd1,   8'h40, 8'd2,   16'h1234, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] task_ptr_i = '0;
    logic [19:0] tbl_base_i = '0;
    logic [15:0] sp_i = '0;
    logic        done_o, mem_req_o, reg_we_o, sp_we_o;
    logic [19:0] mem_addr_o;
    logic [7:0]  mem_rdata_i = '0;
    logic        mem_rvalid_i = 1'b0;
    logic [2:0]  reg_idx_o;
    logic [15:0] reg_wdata_o, sp_wdata_o;

    ctx_restore_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .task_ptr_i(task_ptr_i),
        .tbl_base_i(tbl_base_i), .sp_i(sp_i), .done_o(done_o),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
        .mem_rvalid_i(mem_rvalid_i), .reg_we_o(reg_we_o), .reg_idx_o(reg_idx_o),
        .reg_wdata_o(reg_wdata_o), .sp_we_o(sp_we_o), .sp_wdata_o(sp_wdata_o)
    );

    always #10 clk = ~clk;

    int   n_chk = 0, n_fail = 0;
    vec_t cur;
    int   lat = 0;
    logic [19:0] rd_log [32];
    int   rd_n = 0;
    logic [2:0]  wi_log [16];
    logic [15:0] wd_log [16];
    int   wr_n = 0, done_n = 0, spmis_n = 0;
    logic [15:0] sp_got = '0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_fn(input logic [19:0] a);
        logic [19:0] e;
        e = cur.base + {11'b0, cur.tsk, 1'b0};
        if (a == {4'h0, cur.ptr}) return cur.tsk;
        if (a == e)               return cur.mask;
        if (a == e + 20'd1)       return cur.corr;
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h0, a[19:16]} ^ 8'h3C;
    endfunction

    // Memory responder and output logger, both working on the falling edge.
    initial begin
        int wcnt;
        wcnt = 0;
        forever begin
            @(negedge clk);
            if (reg_we_o && wr_n < 16) begin
                wi_log[wr_n] = reg_idx_o;
                wd_log[wr_n] = reg_wdata_o;
                wr_n++;
            end
            if (done_o) begin
                done_n++;
                sp_got = sp_wdata_o;
            end
            if (sp_we_o != done_o) spmis_n++;
            if (mem_req_o) begin
                if (wcnt >= lat) begin
                    mem_rvalid_i = 1'b1;
                    mem_rdata_i  = mem_fn(mem_addr_o);
                    if (rd_n < 32) rd_log[rd_n] = mem_addr_o;
                    rd_n++;
                    wcnt = 0;
                end else begin
                    mem_rvalid_i = 1'b0;
                    mem_rdata_i  = 8'hEE;
                    wcnt++;
                end
            end else begin
                mem_rvalid_i = 1'b0;
                wcnt = 0;
            end
        end
    end

    task automatic check_idle(input string what);
        chk(!done_o && !mem_req_o && !reg_we_o && !sp_we_o, "R10", what,
            {done_o, mem_req_o, reg_we_o, sp_we_o}, 0);
    endtask

    task automatic run_vec(input vec_t v, input bit inject);
        logic [19:0] exp_rd [32];
        logic [2:0]  exp_wi [16];
        logic [15:0] exp_wd [16];
        logic [19:0] e;
        logic [15:0] s;
        int en, ew, k, bad;
        cur = v; lat = int'(v.lat);
        rd_n = 0; wr_n = 0; done_n = 0; spmis_n = 0;
        @(negedge clk);
        start_i = 1'b1; task_ptr_i = v.ptr; tbl_base_i = v.base; sp_i = v.sp;
        @(negedge clk);
        start_i = 1'b0;
        if (inject) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1; task_ptr_i = 16'h0999; tbl_base_i = '0; sp_i = 16'h0;
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int c = 0; c < 400 && done_n == 0; c++) @(negedge clk);
        repeat (3) @(negedge clk);
        // Expected sequence from the requirements.
        e = v.base + {11'b0, v.tsk, 1'b0};
        exp_rd[0] = {4'h0, v.ptr}; exp_rd[1] = e; exp_rd[2] = e + 20'd1;
        en = 3; ew = 0; k = 0;
        for (int b = 0; b < 8; b++) begin
            if (v.mask[b]) begin
                s = v.sp + 16'(k);
                exp_rd[en] = {4'h0, s};
                exp_rd[en + 1] = {4'h0, s + 16'd1};
                exp_wi[ew] = 3'(b);
                exp_wd[ew] = {mem_fn({4'h0, s + 16'd1}), mem_fn({4'h0, s})};
                en += 2; ew++; k += 2;
            end
        end
        // R1 task-number read address
        chk(rd_n > 0 && rd_log[0] == exp_rd[0], "R1", "task read addr", rd_log[0], exp_rd[0]);
        // R2 mask and correction addresses with 20-bit wrap
        chk(rd_n > 2 && rd_log[1] == exp_rd[1], "R2", "mask addr", rd_log[1], exp_rd[1]);
        chk(rd_n > 2 && rd_log[2] == exp_rd[2], "R2", "corr addr", rd_log[2], exp_rd[2]);
        // R4 / R8 stack read count and addresses
        chk(rd_n == en, "R8", "read count", rd_n, en);
        bad = -1;
        for (int i = 3; i < en && i < rd_n; i++) if (bad < 0 && rd_log[i] != exp_rd[i]) bad = i;
        chk(bad < 0, "R4", "stack read addr",
            bad < 0 ? 0 : rd_log[bad], bad < 0 ? 0 : exp_rd[bad]);
        // R3 selected registers only, in order, with packed data
        chk(wr_n == ew, "R3", "write count", wr_n, ew);
        bad = -1;
        for (int i = 0; i < ew && i < wr_n; i++)
            if (bad < 0 && (wi_log[i] != exp_wi[i] || wd_log[i] != exp_wd[i])) bad = i;
        chk(bad < 0, "R4", "write idx/data",
            bad < 0 ? 0 : {wi_log[bad], wd_log[bad]}, bad < 0 ? 0 : {exp_wi[bad], exp_wd[bad]});
        // R5 corrected SP
        chk(sp_got == v.sp + {8'h0, v.corr}, "R5", "sp result", sp_got, v.sp + {8'h0, v.corr});
        // R7 single done with matching SP strobe
        chk(done_n == 1 && spmis_n == 0, "R7", "done pulses/sp strobe mismatch",
            {done_n, spmis_n}, {32'd1, 32'd0});
        // R6 empty mask: no pops
        if (v.mask == 8'h00)
            chk(rd_n == 3 && wr_n == 0, "R6", "empty mask reads/writes", {rd_n, wr_n}, {32'd3, 32'd0});
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("in reset");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check_idle("after reset");
        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);
        // R9: start pulse in mid-operation must not disturb the run
        run_vec(VECS[0], 1'b1);
        // R10: reset in mid-operation returns to idle, then recovers
        cur = VECS[1]; lat = 2;
        @(negedge clk);
        start_i = 1'b1; task_ptr_i = VECS[1].ptr; tbl_base_i = VECS[1].base; sp_i = VECS[1].sp;
        @(negedge clk); start_i = 1'b0;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_idle("mid-op reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle("after mid-op reset");
        run_vec(VECS[4], 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule